// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block brings a set of converter rails up and down in a configured order. While the board-enable input is high and the input supply is reported valid, it raises an auxiliary interface enable and then turns the rails on one at a time, with a fixed wait between steps. When every rail is on and a separate monitor reports all of them inside their windows for a configured time, it asserts power good. A rail enable output may be shared by several rails, so it stays high while any rail mapped to it is on.

A sequence down has three possible causes: the board-enable input going low, a command strobe, or a fault. Power good is removed at the first edge of every sequence down, and the rails are then released in the reverse of their power-up order. On an over-voltage fault the auxiliary enable drops at once. On any other cause it drops one step after the last rail. After a fault the block stays off until the board-enable input has gone low and come back.

Several reset outputs follow a reset-in input and the window status of the rails chosen for each of them. A command can force any reset output directly.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: A sequence up starts only at a clock edge where `board_en_i` and `vin_ok_i` are both sampled high and no command hold is pending. At that edge `aux_en_o` rises while all rail enables are still low.
- R2: Slot k of the ordering occupies `cfg_order_i[k*IW +: IW]` and names a rail index, where IW is clog2 of the rail count. That rail turns on (cfg_step_dly_i+1)*(k+1) cycles after `aux_en_o` rises.
- R3: `rail_en_o[j]` is high whenever any rail r that is on has bit `cfg_en_map_i[j*N_RAILS + r]` set. A shared output therefore does not change when its second rail switches.
- R4: Power good rises cfg_pg_dly_i+1 cycles after the last rail turns on, counted from the last cycle in which all `rail_inwin_i` bits were high. Any rail out of its window during this wait restarts the count.
- R5: At the first edge of every sequence down, `pg_o` falls before any rail enable falls. Deasserting `board_en_i` while the rails are up or coming up starts a sequence down.
- R6: A sequence down turns the rails off in reverse slot order, one every cfg_step_dly_i+1 cycles. Once started it runs to completion and ignores `board_en_i`.
- R7: Any `rail_ov_i` bit high during power up or operation starts a fault shutdown. At the same edge `aux_en_o` drops. When `cfg_trip_mode_i` is 1, `ovp_trip_o` also rises and stays high until `board_en_i` is low.
- R8: A rail leaving its window during operation starts a fault shutdown in which `aux_en_o` drops cfg_step_dly_i+1 cycles after the last rail turns off.
- R9: After a fault shutdown, all enables stay low until `board_en_i` has been low for at least one edge and is then high again.
- R10: A `cmd_off_i` strobe starts a normal sequence down. No new sequence up begins until `board_en_i` has been low.
- R11: `rst_o[k]` (1 = reset asserted) is high one cycle after `rst_in_i` is high, or after any rail with bit `cfg_rst_mask_i[k*N_RAILS + r]` set is out of its window. Otherwise it is low. All reset outputs are high during `rst_i`.
- R12: While `cmd_rst_ovr_i[k]` is high, `rst_o[k]` takes the value of `cmd_rst_val_i[k]` one cycle later, whatever the state of the reset inputs and rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| board_en_i | input | 1 | Board enable; high requests power up |
| vin_ok_i | input | 1 | Input supply valid |
| rail_inwin_i | input | N_RAILS | Per-rail inside power-good window |
| rail_ov_i | input | N_RAILS | Per-rail above upper limit |
| cmd_off_i | input | 1 | Command strobe: sequence down |
| rst_in_i | input | 1 | Reset request input |
| cmd_rst_ovr_i | input | N_RST | Per-reset command override enable |
| cmd_rst_val_i | input | N_RST | Per-reset override value |
| cfg_order_i | input | N_RAILS*IW | Rail index per power-up slot |
| cfg_en_map_i | input | N_EN*N_RAILS | Rail-to-enable-output mapping |
| cfg_rst_mask_i | input | N_RST*N_RAILS | Rails watched by each reset output |
| cfg_step_dly_i | input | DLY_W | Wait between rail steps |
| cfg_pg_dly_i | input | DLY_W | Power-good qualification wait |
| cfg_trip_mode_i | input | 1 | 1 enables the over-voltage trip output |
| rail_en_o | output | N_EN | Rail enable outputs |
| aux_en_o | output | 1 | Auxiliary interface enable |
| pg_o | output | 1 | Power good |
| ovp_trip_o | output | 1 | Over-voltage trip indication |
| rst_o | output | N_RST | Reset outputs, 1 = in reset |

## Verification
The hardest case to reach is a window drop in the short span after the last rail is on but before power good rises. Only there does the qualification count restart rather than cause a fault. The stimulus counts edges from the board-enable edge, lowers one window bit for exactly two cycles right after the final rail step, and expects power good two cycles later than usual. The shared enable output is also checked at the step where its second rail switches, to show that the port stays unchanged. The two fault paths are told apart by sampling the auxiliary enable at the first shutdown edge and at the step after the last rail.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_UP     = 3'd1,
        SEQ_PGWAIT = 3'd2,
        SEQ_RUN    = 3'd3,
        SEQ_DOWN   = 3'd4,
        SEQ_FOFF   = 3'd5
    } seq_state_e;

    // Reasons for leaving the powered states
    typedef struct packed {
        logic ov;   // over-voltage on any rail
        logic win;  // rail out of window while running
        logic req;  // board enable low or command strobe
    } dn_cause_t;

    function automatic int clog2_min1(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic is_powered(input seq_state_e s);
        return (s == SEQ_UP) || (s == SEQ_PGWAIT) || (s == SEQ_RUN);
    endfunction

    function automatic logic any_cause(input dn_cause_t c);
        return c.ov | c.win | c.req;
    endfunction

    function automatic logic is_fault(input dn_cause_t c);
        return c.ov | c.win;
    endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int N_RAILS = 4,
    parameter int DLY_W   = 8,
    parameter int IDX_W   = clog2_min1(N_RAILS)
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       board_en_i,
    input  logic                       vin_ok_i,
    input  logic [N_RAILS-1:0]         rail_inwin_i,
    input  logic [N_RAILS-1:0]         rail_ov_i,
    input  logic                       cmd_off_i,
    input  logic [N_RAILS*IDX_W-1:0]   cfg_order_i,
    input  logic [DLY_W-1:0]           cfg_step_dly_i,
    input  logic [DLY_W-1:0]           cfg_pg_dly_i,
    input  logic                       cfg_trip_mode_i,
    output logic [N_RAILS-1:0]         rail_on_o,
    output logic                       aux_o,
    output logic                       pg_o,
    output logic                       trip_o
);
    localparam int CNT_W = $clog2(N_RAILS + 1);
    localparam logic [N_RAILS-1:0] RAIL_ONE = N_RAILS'(1);
    localparam logic [CNT_W-1:0]   LAST_UP  = CNT_W'(N_RAILS - 1);

    seq_state_e           state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [DLY_W-1:0]     tmr_q;
    logic [N_RAILS-1:0]   rail_on_q;
    logic                 aux_q, pg_q, trip_q, flt_q, hold_q;

    logic [IDX_W-1:0]     up_sel, dn_sel;
    logic [N_RAILS-1:0]   up_mask, dn_mask;
    dn_cause_t            cause;
    logic                 tmr_done;

    // Slot lookup: rail for the next step up and for the next step down
    always_comb begin
        up_sel = '0;
        dn_sel = '0;
        for (int k = 0; k < N_RAILS; k++) begin
            if (cnt_q == CNT_W'(k))     up_sel = cfg_order_i[k*IDX_W +: IDX_W];
            if (cnt_q == CNT_W'(k + 1)) dn_sel = cfg_order_i[k*IDX_W +: IDX_W];
        end
    end

    assign up_mask  = RAIL_ONE << up_sel;
    assign dn_mask  = RAIL_ONE << dn_sel;
    assign tmr_done = (tmr_q == '0);

    always_comb begin
        cause.ov  = is_powered(state_q) & (|rail_ov_i);
        cause.win = (state_q == SEQ_RUN) & ~(&rail_inwin_i);
        cause.req = is_powered(state_q) & (~board_en_i | cmd_off_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= SEQ_IDLE;
            cnt_q     <= '0;
            tmr_q     <= '0;
            rail_on_q <= '0;
            aux_q     <= 1'b0;
            pg_q      <= 1'b0;
            trip_q    <= 1'b0;
            flt_q     <= 1'b0;
            hold_q    <= 1'b0;
        end else begin
            if (!board_en_i) hold_q <= 1'b0;
            if (is_powered(state_q) && any_cause(cause)) begin
                // Leave the powered states: power good goes first
                state_q <= SEQ_DOWN;
                pg_q    <= 1'b0;
                tmr_q   <= cfg_step_dly_i;
                if (is_fault(cause)) flt_q <= 1'b1;
                if (cause.ov) begin
                    aux_q  <= 1'b0;
                    trip_q <= cfg_trip_mode_i;
                end
                if (cmd_off_i) hold_q <= 1'b1;
            end else begin
                unique case (state_q)
                    SEQ_IDLE: begin
                        if (board_en_i && vin_ok_i && !hold_q) begin
                            state_q <= SEQ_UP;
                            aux_q   <= 1'b1;
                            cnt_q   <= '0;
                            tmr_q   <= cfg_step_dly_i;
                        end
                    end
                    SEQ_UP: begin
                        if (!tmr_done) begin
                            tmr_q <= tmr_q - DLY_W'(1);
                        end else begin
                            rail_on_q <= rail_on_q | up_mask;
                            cnt_q     <= cnt_q + CNT_W'(1);
                            if (cnt_q == LAST_UP) begin
                                state_q <= SEQ_PGWAIT;
                                tmr_q   <= cfg_pg_dly_i;
                            end else begin
                                tmr_q   <= cfg_step_dly_i;
                            end
                        end
                    end
                    SEQ_PGWAIT: begin
                        if (!(&rail_inwin_i)) begin
                            tmr_q <= cfg_pg_dly_i;
                        end else if (!tmr_done) begin
                            tmr_q <= tmr_q - DLY_W'(1);
                        end else begin
                            pg_q    <= 1'b1;
                            state_q <= SEQ_RUN;
                        end
                    end
                    SEQ_RUN: begin
                        pg_q <= 1'b1;
                    end
                    SEQ_DOWN: begin
                        if (!tmr_done) begin
                            tmr_q <= tmr_q - DLY_W'(1);
                        end else if (cnt_q != '0) begin
                            rail_on_q <= rail_on_q & ~dn_mask;
                            cnt_q     <= cnt_q - CNT_W'(1);
                            tmr_q     <= cfg_step_dly_i;
                        end else begin
                            aux_q   <= 1'b0;
                            state_q <= flt_q ? SEQ_FOFF : SEQ_IDLE;
                        end
                    end
                    SEQ_FOFF: begin
                        if (!board_en_i) begin
                            state_q <= SEQ_IDLE;
                            flt_q   <= 1'b0;
                            trip_q  <= 1'b0;
                        end
                    end
                    default: state_q <= SEQ_IDLE;
                endcase
            end
        end
    end

    assign rail_on_o = rail_on_q;
    assign aux_o     = aux_q;
    assign pg_o      = pg_q;
    assign trip_o    = trip_q;

endmodule

// File: rtl/pwr_seq_enmap.sv
module pwr_seq_enmap #(
    parameter int N_RAILS = 4,
    parameter int N_EN    = 3
) (
    input  logic [N_RAILS-1:0]      rail_on_i,
    input  logic [N_EN*N_RAILS-1:0] cfg_en_map_i,
    output logic [N_EN-1:0]         rail_en_o
);
    for (genvar j = 0; j < N_EN; j++) begin : g_en
        assign rail_en_o[j] = |(rail_on_i & cfg_en_map_i[j*N_RAILS +: N_RAILS]);
    end
endmodule

// File: rtl/pwr_seq_rstgen.sv
module pwr_seq_rstgen #(
    parameter int N_RAILS = 4,
    parameter int N_RST   = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       rst_in_i,
    input  logic [N_RAILS-1:0]         rail_inwin_i,
    input  logic [N_RST-1:0]           cmd_rst_ovr_i,
    input  logic [N_RST-1:0]           cmd_rst_val_i,
    input  logic [N_RST*N_RAILS-1:0]   cfg_rst_mask_i,
    output logic [N_RST-1:0]           rst_o
);
    for (genvar k = 0; k < N_RST; k++) begin : g_rst
        logic out_q;
        logic watch_bad;
        assign watch_bad = |(cfg_rst_mask_i[k*N_RAILS +: N_RAILS] & ~rail_inwin_i);
        always_ff @(posedge clk_i) begin
            if (rst_i)                 out_q <= 1'b1;
            else if (cmd_rst_ovr_i[k]) out_q <= cmd_rst_val_i[k];
            else                       out_q <= rst_in_i | watch_bad;
        end
        assign rst_o[k] = out_q;
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int N_RAILS = 4,
    parameter int N_EN    = 3,
    parameter int N_RST   = 2,
    parameter int DLY_W   = 8
) (
    input  logic                                   clk_i,
    input  logic                                   rst_i,
    input  logic                                   board_en_i,
    input  logic                                   vin_ok_i,
    input  logic [N_RAILS-1:0]                     rail_inwin_i,
    input  logic [N_RAILS-1:0]                     rail_ov_i,
    input  logic                                   cmd_off_i,
    input  logic                                   rst_in_i,
    input  logic [N_RST-1:0]                       cmd_rst_ovr_i,
    input  logic [N_RST-1:0]                       cmd_rst_val_i,
    input  logic [N_RAILS*clog2_min1(N_RAILS)-1:0] cfg_order_i,
    input  logic [N_EN*N_RAILS-1:0]                cfg_en_map_i,
    input  logic [N_RST*N_RAILS-1:0]               cfg_rst_mask_i,
    input  logic [DLY_W-1:0]                       cfg_step_dly_i,
    input  logic [DLY_W-1:0]                       cfg_pg_dly_i,
    input  logic                                   cfg_trip_mode_i,
    output logic [N_EN-1:0]                        rail_en_o,
    output logic                                   aux_en_o,
    output logic                                   pg_o,
    output logic                                   ovp_trip_o,
    output logic [N_RST-1:0]                       rst_o
);
    localparam int IDX_W = clog2_min1(N_RAILS);

    logic [N_RAILS-1:0] rail_on;

    pwr_seq_fsm #(
        .N_RAILS (N_RAILS),
        .DLY_W   (DLY_W),
        .IDX_W   (IDX_W)
    ) fsm_i (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .board_en_i      (board_en_i),
        .vin_ok_i        (vin_ok_i),
        .rail_inwin_i    (rail_inwin_i),
        .rail_ov_i       (rail_ov_i),
        .cmd_off_i       (cmd_off_i),
        .cfg_order_i     (cfg_order_i),
        .cfg_step_dly_i  (cfg_step_dly_i),
        .cfg_pg_dly_i    (cfg_pg_dly_i),
        .cfg_trip_mode_i (cfg_trip_mode_i),
        .rail_on_o       (rail_on),
        .aux_o           (aux_en_o),
        .pg_o            (pg_o),
        .trip_o          (ovp_trip_o)
    );

    pwr_seq_enmap #(
        .N_RAILS (N_RAILS),
        .N_EN    (N_EN)
    ) enmap_i (
        .rail_on_i    (rail_on),
        .cfg_en_map_i (cfg_en_map_i),
        .rail_en_o    (rail_en_o)
    );

    pwr_seq_rstgen #(
        .N_RAILS (N_RAILS),
        .N_RST   (N_RST)
    ) rstgen_i (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .rst_in_i       (rst_in_i),
        .rail_inwin_i   (rail_inwin_i),
        .cmd_rst_ovr_i  (cmd_rst_ovr_i),
        .cmd_rst_val_i  (cmd_rst_val_i),
        .cfg_rst_mask_i (cfg_rst_mask_i),
        .rst_o          (rst_o)
    );

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int N_RAILS = 4,
    parameter int N_EN    = 3,
    parameter int N_RST   = 2
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      board_en_i,
    input logic                      vin_ok_i,
    input logic [N_RAILS-1:0]        rail_inwin_i,
    input logic [N_EN-1:0]           rail_en_o,
    input logic                      aux_en_o,
    input logic                      pg_o,
    input logic                      ovp_trip_o,
    input logic                      rst_in_i,
    input logic [N_RST-1:0]          cmd_rst_ovr_i,
    input logic [N_RST-1:0]          cmd_rst_val_i,
    input logic [N_RST-1:0]          rst_o,
    input logic [N_EN*N_RAILS-1:0]   cfg_en_map_i
);
    logic [N_EN-1:0] used_en;
    always_comb begin
        for (int j = 0; j < N_EN; j++) used_en[j] = |cfg_en_map_i[j*N_RAILS +: N_RAILS];
    end

    // R1
    start_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(aux_en_o) |-> $past(board_en_i && vin_ok_i));

    // R5
    pg_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|($past(rail_en_o) & ~rail_en_o)) |-> (!pg_o && !$past(pg_o)));

    // R4
    pg_win_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pg_o) |-> $past(&rail_inwin_i));

    // R3
    pg_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pg_o |-> (aux_en_o && (rail_en_o == used_en)));

    // R7
    trip_aux_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ovp_trip_o |-> !aux_en_o);

    // R11
    rst_in_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rst_in_i && (cmd_rst_ovr_i == '0)) |=> (&rst_o));

    for (genvar k = 0; k < N_RST; k++) begin : g_ovr
        // R12
        rst_ovr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            cmd_rst_ovr_i[k] |=> (rst_o[k] == $past(cmd_rst_val_i[k])));
    end
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
    .N_RAILS (N_RAILS),
    .N_EN    (N_EN),
    .N_RST   (N_RST)
) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .board_en_i    (board_en_i),
    .vin_ok_i      (vin_ok_i),
    .rail_inwin_i  (rail_inwin_i),
    .rail_en_o     (rail_en_o),
    .aux_en_o      (aux_en_o),
    .pg_o          (pg_o),
    .ovp_trip_o    (ovp_trip_o),
    .rst_in_i      (rst_in_i),
    .cmd_rst_ovr_i (cmd_rst_ovr_i),
    .cmd_rst_val_i (cmd_rst_val_i),
    .rst_o         (rst_o),
    .cfg_en_map_i  (cfg_en_map_i)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;
    localparam int NE = 3;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          board_en, vin_ok, cmd_off, rst_in, trip_mode;
    logic [NR-1:0] inwin, ov;
    logic [NS-1:0] ovr, oval;
    logic [NE-1:0] en;
    logic          aux, pg, trip;
    logic [NS-1:0] rsto;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slots 0..3 = rails 2,0,3,1 ; enables: 0 <- rails 0,1 ; 1 <- rail 2 ; 2 <- rail 3
    // Step wait 3 (period 4 cycles), power-good wait 5
    pwr_seq_ctrl #(.N_RAILS(NR), .N_EN(NE), .N_RST(NS), .DLY_W(8)) dut_i (
        .clk_i           (clk),
        .rst_i           (rst),
        .board_en_i      (board_en),
        .vin_ok_i        (vin_ok),
        .rail_inwin_i    (inwin),
        .rail_ov_i       (ov),
        .cmd_off_i       (cmd_off),
        .rst_in_i        (rst_in),
        .cmd_rst_ovr_i   (ovr),
        .cmd_rst_val_i   (oval),
        .cfg_order_i     ({2'd1, 2'd3, 2'd0, 2'd2}),
        .cfg_en_map_i    ({4'b1000, 4'b0100, 4'b0011}),
        .cfg_rst_mask_i  ({4'b1111, 4'b0011}),
        .cfg_step_dly_i  (8'd3),
        .cfg_pg_dly_i    (8'd5),
        .cfg_trip_mode_i (trip_mode),
        .rail_en_o       (en),
        .aux_en_o        (aux),
        .pg_o            (pg),
        .ovp_trip_o      (trip),
        .rst_o           (rsto)
    );

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; board_en = 0; vin_ok = 0; cmd_off = 0; rst_in = 0; trip_mode = 1;
        inwin = '1; ov = '0; ovr = '0; oval = '0;
        adv(3);
        chk("R11 reset rst_o", rsto, 2'b11);
        chk("R1 reset aux", aux, 0);
        chk("R1 reset en", en, 0);
        chk("R4 reset pg", pg, 0);
        rst = 1'b0;
        adv(1);
        chk("R11 rst_o released", rsto, 2'b00);
    endtask

    task automatic t_gate;
        board_en = 1; vin_ok = 0;
        adv(8);
        chk("R1 no start without vin", aux, 0);
        chk("R1 no rails without vin", en, 0);
        board_en = 0; vin_ok = 1;
        adv(4);
        chk("R1 no start without board_en", aux, 0);
    endtask

    // Full power-up with a window glitch during the power-good wait
    task automatic t_up;
        board_en = 1;
        adv(1);
        chk("R1 aux first", aux, 1);
        chk("R1 rails off at start", en, 0);
        adv(3);
        chk("R2 slot0 not yet", en, 3'b000);
        adv(1);
        chk("R2 slot0 rail2", en, 3'b010);
        adv(4);
        chk("R2 slot1 rail0", en, 3'b011);
        adv(4);
        chk("R2 slot2 rail3", en, 3'b111);
        adv(4);
        chk("R3 shared enable unchanged", en, 3'b111);
        chk("R4 no pg yet", pg, 0);
        inwin = 4'b1110;
        adv(2);
        inwin = 4'b1111;
        adv(5);
        chk("R4 pg restarted", pg, 0);
        adv(1);
        chk("R4 pg asserted", pg, 1);
    endtask

    task automatic t_down_normal;
        board_en = 0;
        adv(1);
        chk("R5 pg drops first", pg, 0);
        chk("R5 rails still on", en, 3'b111);
        adv(7);
        chk("R3 shared off no change", en, 3'b111);
        adv(1);
        chk("R6 rail3 off", en, 3'b011);
        board_en = 1;
        adv(4);
        chk("R6 rail0 off ignores board_en", en, 3'b010);
        adv(4);
        chk("R6 rail2 off", en, 3'b000);
        chk("R6 aux held", aux, 1);
        adv(3);
        chk("R6 aux still held", aux, 1);
        adv(1);
        chk("R6 aux off last", aux, 0);
        adv(1);
        chk("R1 restart", aux, 1);
        adv(22);
        chk("R4 pg after restart", pg, 1);
    endtask

    task automatic t_ov(input logic mode);
        trip_mode = mode;
        ov = 4'b0100;
        adv(1);
        ov = '0;
        chk("R7 pg off", pg, 0);
        chk("R7 aux first", aux, 0);
        chk("R7 trip", trip, mode);
        chk("R7 rails on", en, 3'b111);
        adv(8);
        chk("R6 ov down order", en, 3'b011);
        adv(8);
        chk("R7 rails off", en, 3'b000);
        adv(14);
        chk("R9 stays off aux", aux, 0);
        chk("R9 stays off en", en, 3'b000);
        chk("R7 trip held", trip, mode);
        board_en = 0;
        adv(1);
        chk("R7 trip cleared", trip, 0);
        adv(1);
        board_en = 1;
        adv(1);
        chk("R9 restart after toggle", aux, 1);
        adv(22);
        chk("R9 pg after fault restart", pg, 1);
    endtask

    task automatic t_win;
        inwin = 4'b0111;
        adv(1);
        chk("R8 pg off", pg, 0);
        chk("R8 aux kept", aux, 1);
        chk("R11 mask reset", rsto, 2'b10);
        adv(16);
        chk("R8 rails off", en, 3'b000);
        chk("R8 aux still on", aux, 1);
        adv(4);
        chk("R8 aux off last", aux, 0);
        inwin = 4'b1111;
        adv(1);
        chk("R11 resets release", rsto, 2'b00);
        adv(5);
        chk("R9 fault hold", aux, 0);
        board_en = 0;
        adv(1);
        board_en = 1;
        adv(1);
        chk("R9 restart", aux, 1);
        adv(22);
        chk("R4 pg again", pg, 1);
    endtask

    task automatic t_cmd;
        cmd_off = 1;
        adv(1);
        cmd_off = 0;
        chk("R10 pg off", pg, 0);
        adv(20);
        chk("R10 down done", aux, 0);
        chk("R10 rails off", en, 3'b000);
        adv(6);
        chk("R10 held off", aux, 0);
        board_en = 0;
        adv(1);
        board_en = 1;
        adv(1);
        chk("R10 restart after toggle", aux, 1);
        adv(22);
        chk("R10 pg", pg, 1);
    endtask

    task automatic t_rst;
        rst_in = 1;
        adv(1);
        chk("R11 rst_in", rsto, 2'b11);
        chk("R11 fsm unaffected", pg, 1);
        rst_in = 0;
        adv(1);
        chk("R11 rst_in released", rsto, 2'b00);
        ovr = 2'b01; oval = 2'b00; rst_in = 1;
        adv(1);
        chk("R12 force low", rsto, 2'b10);
        ovr = 2'b10; oval = 2'b10; rst_in = 0;
        adv(1);
        chk("R12 force high", rsto, 2'b10);
        ovr = 2'b00;
        adv(1);
        chk("R12 release", rsto, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_gate();
        t_up();
        t_down_normal();
        t_ov(1'b1);
        t_ov(1'b0);
        t_win();
        t_cmd();
        t_rst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule